// File: doc/BRIEF.md
# Periodic Interval Timer

This peripheral produces a steady time base for software. A free-running prescaler divides the system clock by 16, and each prescaled tick advances a 20-bit interval counter. When the counter passes the programmed limit, it returns to zero and a period event occurs. Each period event sets a status flag and adds one to a 12-bit count of elapsed periods. An optional level interrupt follows the flag.

Software uses a single-cycle register bus. Reading the value register acknowledges: it returns a snapshot of both counters and clears the elapsed-period count and the flag. Reading the image register returns the same snapshot and changes nothing. Software can therefore sample time without consuming pending periods. When the enable bit is cleared, the counter runs out its current period and stops at zero.

Top module: `pit_timer`

## Requirements
- R1: After reset, all four registers read zero, the prescaler restarts at phase zero and `irq` is low.
- R2: While the timer runs, the interval counter advances by exactly one every 16 clock cycles.
- R3: The period event happens on a prescaled tick when the counter is at or above the limit held in mode bits 19:0. On that tick the counter returns to zero. A limit of L therefore gives a period of L+1 ticks.
- R4: When the enable bit is cleared, the counter keeps counting until it wraps to zero. It then holds at zero until the enable bit is set again.
- R5: Each period event sets status bit 0 and increments the elapsed-period count.
- R6: A read at address 2 (value) returns the snapshot {periods[11:0] in bits 31:20, counter in bits 19:0}. At the end of that cycle it clears the period count and the flag. If a period event falls in the same cycle, the count becomes 1 and the flag stays set.
- R7: A read at address 3 (image) returns the same snapshot word and has no effect on the count or the flag.
- R8: The elapsed-period count saturates at 4095 and does not wrap to zero.
- R9: `irq` is high exactly when the flag is set and the interrupt-enable bit is set. With interrupt-enable clear, counting and the period count continue but `irq` stays low.
- R10: The mode register at address 0 holds the limit in bits 19:0, the timer enable in bit 24 and the interrupt enable in bit 25, and reads back what was written. Writes to addresses 1, 2 and 3 are ignored. Address 1 reads the flag in bit 0. `bus_rdata` is zero when `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| irq | output | 1 | Level interrupt request |

## Verification
An acknowledging read and a period event can occur in the same clock cycle. The read then clears the count while the wrap adds to it. The bench forces this case directly: it sets the limit to zero so that every tick wraps, follows the prescaler phase in its own model, and issues a value read exactly on the tick cycle. It then reads status and image to confirm that the flag is still set and the count is exactly one. The randomised phase issues many value reads against the same model, so the collision also occurs at arbitrary counts and limits.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [1:0] {
    REG_MODE  = 2'd0,
    REG_STAT  = 2'd1,
    REG_VALUE = 2'd2,
    REG_IMAGE = 2'd3
  } pit_reg_e;

  localparam int MODE_EN_BIT  = 24;
  localparam int MODE_IEN_BIT = 25;

  // Saturating increment of a count held in the low bits of a word.
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] maxv);
    return (v >= maxv) ? maxv : v + 32'd1;
  endfunction

  // Pack the period count above the interval counter.
  function automatic logic [31:0] pack_snap(input logic [31:0] periods,
                                            input logic [31:0] count,
                                            input int          cnt_w);
    return (periods << cnt_w) | count;
  endfunction

endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] phase_q;

  assign tick = (phase_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    phase_q <= '0;
    else if (tick) phase_q <= '0;
    else           phase_q <= phase_q + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_spacing
      a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/pit_interval_counter.sv
module pit_interval_counter #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         enable,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         wrap
);
  logic active;

  // Keeps running after the enable drops, until zero is reached.
  assign active = enable || (count != '0);
  assign wrap   = tick && active && (count >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)                count <= '0;
    else if (tick && active)   count <= wrap ? '0 : count + 1'b1;
  end

  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count == '0));
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && count == '0) |=> (count == '0));
  a_r2_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
endmodule

// File: rtl/pit_period_tracker.sv
module pit_period_tracker #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wrap,
  input  logic         ack,
  output logic [W-1:0] periods,
  output logic         flag
);
  import pit_pkg::*;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] bumped;
  assign bumped = W'(sat_inc(32'(periods), 32'(MAXV)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      periods <= '0;
      flag    <= 1'b0;
    end else if (wrap) begin
      periods <= ack ? W'(1) : bumped;
      flag    <= 1'b1;
    end else if (ack) begin
      periods <= '0;
      flag    <= 1'b0;
    end
  end

  a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag);
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wrap) |=> (periods == '0 && !flag));
  a_r6_ack_with_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && wrap) |=> (periods == W'(1)));
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (periods == MAXV && !ack) |=> (periods == MAXV));
endmodule

// File: rtl/pit_timer.sv
module pit_timer #(
  parameter int PRESCALE = 16,
  parameter int CNT_W    = 20,
  parameter int PCNT_W   = 12,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import pit_pkg::*;

  logic [CNT_W-1:0]  limit_q;
  logic              en_q, ien_q;
  logic              tick, wrap, flag, ack_fire, mode_wr;
  logic [CNT_W-1:0]  count;
  logic [PCNT_W-1:0] periods;
  logic [DATA_W-1:0] snap_word, mode_word;

  assign mode_wr  = bus_wr && (pit_reg_e'(bus_addr) == REG_MODE);
  assign ack_fire = bus_rd && (pit_reg_e'(bus_addr) == REG_VALUE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limit_q <= '0;
      en_q    <= 1'b0;
      ien_q   <= 1'b0;
    end else if (mode_wr) begin
      limit_q <= bus_wdata[CNT_W-1:0];
      en_q    <= bus_wdata[MODE_EN_BIT];
      ien_q   <= bus_wdata[MODE_IEN_BIT];
    end
  end

  pit_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  pit_interval_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(en_q),
    .limit(limit_q), .count(count), .wrap(wrap)
  );

  pit_period_tracker #(.W(PCNT_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .ack(ack_fire),
    .periods(periods), .flag(flag)
  );

  assign snap_word = DATA_W'(pack_snap(32'(periods), 32'(count), CNT_W));

  always_comb begin
    mode_word = '0;
    mode_word[CNT_W-1:0]   = limit_q;
    mode_word[MODE_EN_BIT]  = en_q;
    mode_word[MODE_IEN_BIT] = ien_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (pit_reg_e'(bus_addr))
        REG_MODE:  bus_rdata = mode_word;
        REG_STAT:  bus_rdata = DATA_W'(flag);
        REG_VALUE,
        REG_IMAGE: bus_rdata = snap_word;
      endcase
    end
  end

  assign irq = flag & ien_q;

  a_r9_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack_fire && !mode_wr) |=> irq);
  a_r10_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |=> ($stable(limit_q) && $stable(en_q) && $stable(ien_q)));
  a_r7_image_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !ack_fire) |=> flag);
endmodule

// File: tb/test_pit_timer.sv
`timescale 1ns/1ps
module test_pit_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  pit_timer i_pit_timer (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // Reference model written from the requirements.
  int          m_pre, m_cnt, m_pc;
  logic        m_fl, m_en, m_ien;
  int          m_lim;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre <= 0; m_cnt <= 0; m_pc <= 0; m_fl <= 0;
      m_en <= 0; m_ien <= 0; m_lim <= 0;
    end else begin : upd
      bit t, run, w, a;
      t   = (m_pre == 15);
      run = m_en || (m_cnt != 0);
      w   = t && run && (m_cnt >= m_lim);
      a   = bus_rd && (bus_addr == 2'd2);
      m_pre <= (m_pre + 1) % 16;
      if (t && run) m_cnt <= w ? 0 : m_cnt + 1;
      if (w) begin
        m_fl <= 1;
        if (a)              m_pc <= 1;
        else if (m_pc < 4095) m_pc <= m_pc + 1;
      end else if (a) begin
        m_pc <= 0; m_fl <= 0;
      end
      if (bus_wr && bus_addr == 2'd0) begin
        m_lim <= int'(bus_wdata[19:0]);
        m_en  <= bus_wdata[24];
        m_ien <= bus_wdata[25];
      end
    end
  end

  function automatic logic [31:0] expect_word(input logic [1:0] a);
    case (a)
      2'd0:    return {6'd0, m_ien, m_en, 4'd0, m_lim[19:0]};
      2'd1:    return {31'd0, m_fl};
      default: return {m_pc[11:0], m_cnt[19:0]};
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic do_read(input logic [1:0] a, input string req, output logic [31:0] got);
    logic [31:0] e;
    bus_rd = 1'b1; bus_addr = a;
    #1;
    got = bus_rdata;
    e = expect_word(a);
    check(got === e, req, got, e);
    check(irq === (m_fl & m_ien), "R9 irq level", {31'd0, irq}, {31'd0, m_fl & m_ien});
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic do_write(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  function automatic logic [31:0] mode_val(input int lim, input bit en, input bit ien);
    return (32'(ien) << 25) | (32'(en) << 24) | 32'(lim & 20'hFFFFF);
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] r, r2;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      do_read(2'(a), "R1 reset", r);
      check(r == 32'd0, "R1 reset zero", r, 0);
    end
    check(irq == 1'b0, "R1 irq low", {31'd0, irq}, 0);

    // R2 advance rate and R10 readback
    do_write(2'd0, mode_val(1000, 1, 0));
    do_read(2'd0, "R10 mode readback", r);
    idle(40);
    do_read(2'd3, "R2 image", r);
    idle(31);
    do_read(2'd3, "R2 image", r2);
    check(r2[19:0] - r[19:0] == 20'd2, "R2 two ticks per 32 cycles", r2 - r, 2);

    // R10 writes to other addresses ignored
    do_write(2'd1, 32'hFFFF_FFFF);
    do_write(2'd2, 32'hFFFF_FFFF);
    do_write(2'd3, 32'hFFFF_FFFF);
    do_read(2'd0, "R10 mode unchanged", r);
    check(r == mode_val(1000, 1, 0), "R10 ignored writes", r, mode_val(1000, 1, 0));

    // R3 wrap with limit 9; R4 finish period then hold
    do_write(2'd0, mode_val(9, 1, 0));
    do_read(2'd2, "R6 ack", r);
    idle(16 * 30);
    do_read(2'd3, "R3 image after wraps", r);
    check(r[31:20] >= 12'd1, "R5 periods counted", r, 1);
    idle(16 * 3);
    do_write(2'd0, mode_val(9, 0, 0));
    idle(16 * 12);
    do_read(2'd3, "R4 run out", r);
    check(r[19:0] == 20'd0, "R4 counter at zero", r, 0);
    idle(16 * 5);
    do_read(2'd3, "R4 holds", r2);
    check(r2 == r, "R4 holds and R7 image no side effect", r2, r);

    // R9 interrupt gating
    do_write(2'd0, mode_val(0, 1, 0));
    idle(40);
    do_read(2'd1, "R5 status set", r);
    check(r == 32'd1 && irq == 1'b0, "R9 masked irq", {r[30:0], irq}, 32'd2);
    do_write(2'd0, mode_val(0, 1, 1));
    check(irq == 1'b1, "R9 irq raised by enable", {31'd0, irq}, 1);
    do_read(2'd3, "R7 image keeps flag", r);
    check(irq == 1'b1, "R7 image does not ack", {31'd0, irq}, 1);

    // R6 ack colliding with a period event (limit 0: every tick wraps)
    do_write(2'd0, mode_val(0, 1, 1));
    while (m_pre != 15) @(negedge clk);
    do_read(2'd2, "R6 ack on tick", r);
    do_read(2'd1, "R6 flag survives", r);
    check(r == 32'd1, "R6 flag after collision", r, 1);
    do_read(2'd3, "R6 count one", r);
    check(r[31:20] == 12'd1, "R6 count after collision", r[31:20], 1);
    // Plain ack away from a tick
    while (m_pre != 3) @(negedge clk);
    do_read(2'd2, "R6 plain ack", r);
    do_read(2'd3, "R6 cleared", r);
    check(r[31:20] == 12'd0 && irq == 1'b0, "R6 cleared count and irq", r, 0);

    // R8 saturation
    do_write(2'd0, mode_val(0, 1, 0));
    do_read(2'd2, "R6 ack", r);
    idle(16 * 4100);
    do_read(2'd3, "R8 saturated", r);
    check(r[31:20] == 12'd4095, "R8 count at 4095", r[31:20], 4095);

    // Constrained random mix
    for (int i = 0; i < 300; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 2)
        do_write(2'd0, mode_val($urandom_range(0, 5), $urandom_range(0, 3) != 0, $urandom_range(0, 1)));
      else if (op < 3)
        do_write(2'($urandom_range(1, 3)), $urandom());
      else
        do_read(2'($urandom_range(0, 3)), "R3 R5 R6 R7 random", r);
      idle($urandom_range(0, 40));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule